// File: doc/BRIEF.md
# JTAG Pin-Sharing Enable Controller

Four pads of a device are shared between a general-purpose I/O port and a JTAG test port. This block decides, on every system clock, which of the two functions owns the pads. The test function is switched on when any of three sources is asserted. The sources are a static configuration input, a run-time enable bit that the host writes over a small register bus, and an external logic-term input. The logic-term input is synchronised before use.

While the test function owns the pads, pad 0 carries TMS, pad 1 carries TCK, pad 2 carries TDI and pad 3 carries TDO. The first three are always inputs in this mode. TDO stays an input until the test access port signals, with a one-cycle command pulse, that the external test controller has enabled it. The same command can also turn on two extra status pads, if a static option allows it.

Reset has different effects on the enable sources. It clears the run-time bit, which stops a port that only the register had enabled. A port held on by the static configuration input keeps running through reset.

Top module: `jtag_pin_share`

## Requirements
- R1: The output `jtag_on` is the OR of `cfg_jtag_en`, the register enable bit and `pt_jtag_en`. `pt_jtag_en` passes through a two-stage synchroniser, so `jtag_on` follows a change on it after the second rising edge.
- R2: While `jtag_on` is high, pads 0 to 2 are inputs, and `tap_tms`/`tap_tck`/`tap_tdi` follow `pad_in[0]`/`pad_in[1]`/`pad_in[2]` after two edges. While it is low, `pad_oe`/`pad_out` take `gpio_oe`/`gpio_out` one edge later.
- R3: The enable register is at address `REG_ADDR` (default C7h), with the enable in bit 0 (1 = enabled). Bits 7:1 always read 0. Any other address reads 0, and writes to any other address change nothing.
- R4: Reset clears the register enable bit. Writing a value with bit 0 = 0 also clears it.
- R5: When `cfg_jtag_en` is high, reset changes neither `jtag_on`, nor the TDO drive, nor the TMS/TCK/TDI routing. When only the register bit enables the port, reset turns it off and hands the pads back to GPIO.
- R6: `pad_oe[3]` stays 0 in test mode until `tap_enable_cmd` is pulsed. After the pulse, pad 3 drives `tap_tdo`. Whenever `jtag_on` goes low, the TDO drive is lost, and a new pulse is needed after re-enabling.
- R7: `stat_oe` is 2'b11 only when `cfg_stat_en` is high, test mode is on and TDO has been enabled. `stat_out` is then {`tap_terr`, `tap_tstat`}. Otherwise both are 0.
- R8: In test mode `gpio_in` reads 0. Outside it, `gpio_in` follows `pad_in` after two edges and the TAP inputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Device reset, active low, synchronous |
| cfg_jtag_en | input | 1 | Static configuration enable for the test port |
| cfg_stat_en | input | 1 | Static option allowing the two status pads |
| pt_jtag_en | input | 1 | Asynchronous logic-term enable |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | AW | Register bus address |
| bus_wdata | input | DW | Register bus write data |
| bus_rdata | output | DW | Register bus read data (combinational) |
| tap_enable_cmd | input | 1 | One-cycle pulse: test controller enabled TDO |
| tap_tdo | input | 1 | TDO value from the TAP |
| tap_tstat | input | 1 | Status value from the TAP |
| tap_terr | input | 1 | Error value from the TAP |
| tap_tms | output | 1 | TMS toward the TAP |
| tap_tck | output | 1 | TCK toward the TAP |
| tap_tdi | output | 1 | TDI toward the TAP |
| gpio_out | input | 4 | GPIO output values |
| gpio_oe | input | 4 | GPIO output enables |
| gpio_in | output | 4 | Synchronised pad values toward GPIO |
| pad_in | input | 4 | Pad input values |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| stat_out | output | 2 | Status pad values {error, status} |
| stat_oe | output | 2 | Status pad output enables |
| jtag_on | output | 1 | Test function owns the shared pads |

## Verification
The bench targets the asymmetric reset rule. It checks that a port enabled by the static bit keeps TDO driven and TMS routed while reset is held, and that a register-only port drops back to GPIO. A design that reset everything would break the first case. A design that ignored reset would break the second. It also re-enables the port without a new command, so a TDO flag that outlives a disable would be caught. Writes with upper bits set and writes to a neighbouring address expose a design that stores stray bits or decodes too few address bits. A one-cycle probe of the logic-term latency catches a missing or extra synchroniser stage.

// File: rtl/jtag_pin_share.sv
`timescale 1ns/1ps
module jtag_pin_share #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'hC7,
  parameter int SYNC = 2,
  parameter int NPAD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_jtag_en,
  input  logic          cfg_stat_en,
  input  logic          pt_jtag_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tap_enable_cmd,
  input  logic          tap_tdo,
  input  logic          tap_tstat,
  input  logic          tap_terr,
  output logic          tap_tms,
  output logic          tap_tck,
  output logic          tap_tdi,
  input  logic [NPAD-1:0] gpio_out,
  input  logic [NPAD-1:0] gpio_oe,
  output logic [NPAD-1:0] gpio_in,
  input  logic [NPAD-1:0] pad_in,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] pad_oe,
  output logic [1:0]    stat_out,
  output logic [1:0]    stat_oe,
  output logic          jtag_on
);
  localparam int PW = SYNC * NPAD;

  logic [SYNC-1:0] pt_pipe;
  logic [PW-1:0]   pad_pipe;
  logic [NPAD-1:0] pad_s;
  logic            pt_s;
  logic            reg_en;
  logic            reg_hit;
  logic            tdo_act;
  logic            stat_live;

  always_ff @(posedge clk) begin
    if (!rst_n) pt_pipe <= '0;
    else        pt_pipe <= {pt_pipe[SYNC-2:0], pt_jtag_en};
  end

  always_ff @(posedge clk) pad_pipe <= {pad_pipe[PW-NPAD-1:0], pad_in};

  assign pt_s  = pt_pipe[SYNC-1];
  assign pad_s = pad_pipe[PW-1 -: NPAD];

  assign reg_hit = bus_sel && (bus_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)                reg_en <= 1'b0;
    else if (reg_hit && bus_wr) reg_en <= bus_wdata[0];
  end

  assign bus_rdata = reg_hit ? {{(DW-1){1'b0}}, reg_en} : '0;
  assign jtag_on   = cfg_jtag_en | reg_en | pt_s;

  always_ff @(posedge clk) begin
    if (!jtag_on || (!rst_n && !cfg_jtag_en)) tdo_act <= 1'b0;
    else if (tap_enable_cmd)                  tdo_act <= 1'b1;
  end

  assign stat_live = jtag_on & tdo_act & cfg_stat_en;

  always_ff @(posedge clk) begin
    pad_oe   <= jtag_on ? {tdo_act, {(NPAD-1){1'b0}}} : gpio_oe;
    pad_out  <= jtag_on ? {tap_tdo & tdo_act, {(NPAD-1){1'b0}}} : gpio_out;
    stat_oe  <= {2{stat_live}};
    stat_out <= stat_live ? {tap_terr, tap_tstat} : 2'b00;
  end

  assign gpio_in = jtag_on ? '0 : pad_s;
  assign tap_tms = jtag_on & pad_s[0];
  assign tap_tck = jtag_on & pad_s[1];
  assign tap_tdi = jtag_on & pad_s[2];

  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> bus_rdata[DW-1:1] == '0); // R3
  AST_REG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !reg_en); // R4
  AST_SHARED_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(jtag_on) |-> pad_oe[NPAD-2:0] == '0); // R2
  AST_TDO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jtag_on) && !tap_enable_cmd |=> !pad_oe[NPAD-1]); // R6
  AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !jtag_on |=> !tdo_act); // R6
  AST_STAT_NEEDS_TDO: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_oe) |-> pad_oe[NPAD-1]); // R7
endmodule

// File: tb/jtag_pin_share_tb.sv
`timescale 1ns/1ps
module jtag_pin_share_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_jtag_en = 0, cfg_stat_en = 0, pt_jtag_en = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic tap_enable_cmd = 0, tap_tdo = 0, tap_tstat = 0, tap_terr = 0;
  logic tap_tms, tap_tck, tap_tdi, jtag_on;
  logic [3:0] gpio_out = 4'b0110, gpio_oe = 4'b1010, gpio_in, pad_in = 0, pad_out, pad_oe;
  logic [1:0] stat_out, stat_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jtag_pin_share dut_i (.*);

  typedef struct packed {
    logic cfg; logic pt; logic wr; logic [7:0] wv; logic cmd; logic sc;
    logic on; logic [3:0] oe; logic [1:0] st; logic [7:0] rd;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,4'b1010,2'b00,8'h00},
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,4'b0000,2'b00,8'h00},
    '{1'b1,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,4'b1000,2'b00,8'h00},
    '{1'b0,1'b0,1'b1,8'h01,1'b1,1'b0, 1'b1,4'b1000,2'b00,8'h01},
    '{1'b0,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,4'b0000,2'b00,8'h00},
    '{1'b0,1'b1,1'b0,8'h00,1'b1,1'b1, 1'b1,4'b1000,2'b11,8'h00},
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1, 1'b1,4'b0000,2'b00,8'h00},
    '{1'b0,1'b0,1'b1,8'hFF,1'b0,1'b0, 1'b1,4'b0000,2'b00,8'h01},
    '{1'b0,1'b0,1'b1,8'hFE,1'b1,1'b0, 1'b0,4'b1010,2'b00,8'h00}
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic read_reg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_addr = a; #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse_cmd;
    @(negedge clk); tap_enable_cmd = 1;
    @(negedge clk); tap_enable_cmd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all;
    cfg_jtag_en = 0; pt_jtag_en = 0; cfg_stat_en = 0;
    bus_write(8'hC7, 8'h00);
    idle(5);
  endtask

  initial begin
    logic [7:0] rd;
    idle(4);
    check("R4", "reg at reset", {31'b0, jtag_on}, 0);
    rst_n = 1;
    idle(3);
    read_reg(8'hC7, rd);
    check("R4", "reg after reset", rd, 8'h00);
    check("R2", "gpio oe after reset", pad_oe, 4'b1010);

    foreach (VEC[i]) begin
      cfg_jtag_en = VEC[i].cfg; pt_jtag_en = VEC[i].pt; cfg_stat_en = VEC[i].sc;
      if (VEC[i].wr) bus_write(8'hC7, VEC[i].wv);
      idle(4);
      if (VEC[i].cmd) pulse_cmd();
      idle(3);
      check("R1", $sformatf("vec%0d jtag_on", i), {31'b0, jtag_on}, {31'b0, VEC[i].on});
      check("R6", $sformatf("vec%0d pad_oe", i), pad_oe, VEC[i].oe);
      check("R7", $sformatf("vec%0d stat_oe", i), stat_oe, VEC[i].st);
      read_reg(8'hC7, rd);
      check("R3", $sformatf("vec%0d readback", i), rd, VEC[i].rd);
      clear_all();
    end

    // R1 synchroniser latency
    @(negedge clk); pt_jtag_en = 1;
    @(negedge clk); check("R1", "pt after one edge", {31'b0, jtag_on}, 0);
    @(negedge clk); check("R1", "pt after two edges", {31'b0, jtag_on}, 1);
    clear_all();

    // R8 / R2 routing while off
    pad_in = 4'b0101; idle(3);
    check("R8", "gpio_in off", gpio_in, 4'b0101);
    check("R8", "tap inputs off", {29'b0, tap_tdi, tap_tck, tap_tms}, 0);
    check("R2", "pad_out off", pad_out, 4'b0110);

    // R2 / R6 / R7 routing while on
    cfg_jtag_en = 1; cfg_stat_en = 1; tap_tdo = 1; tap_tstat = 1; tap_terr = 0;
    idle(3);
    check("R8", "gpio_in on", gpio_in, 4'b0000);
    check("R2", "tap inputs on", {29'b0, tap_tdi, tap_tck, tap_tms}, 3'b101);
    check("R6", "tdo input before cmd", pad_oe, 4'b0000);
    pulse_cmd(); idle(2);
    check("R6", "tdo driven", pad_out, 4'b1000);
    check("R7", "stat_out", stat_out, 2'b01);

    // R5 reset while held on by the static bit
    rst_n = 0; idle(4);
    check("R5", "cfg reset jtag_on", {31'b0, jtag_on}, 1);
    check("R5", "cfg reset tdo oe", pad_oe, 4'b1000);
    check("R5", "cfg reset tms route", {31'b0, tap_tms}, 1);
    rst_n = 1; idle(2);
    check("R5", "cfg after reset tdo oe", pad_oe, 4'b1000);
    clear_all();

    // R6 re-enable needs a new command
    cfg_jtag_en = 1; idle(4);
    check("R6", "re-enable without cmd", pad_oe, 4'b0000);
    clear_all();

    // R5 / R4 reset with only the register enable
    bus_write(8'hC7, 8'h01); pulse_cmd(); idle(2);
    check("R6", "reg-only tdo oe", pad_oe, 4'b1000);
    rst_n = 0; idle(3);
    check("R5", "reg reset jtag_on", {31'b0, jtag_on}, 0);
    check("R5", "reg reset pads to gpio", pad_oe, 4'b1010);
    rst_n = 1; idle(2);
    read_reg(8'hC7, rd);
    check("R4", "reg cleared by reset", rd, 8'h00);

    // R4 write clear
    bus_write(8'hC7, 8'h01); idle(1);
    check("R4", "write set", {31'b0, jtag_on}, 1);
    bus_write(8'hC7, 8'h00); idle(1);
    check("R4", "write clear", {31'b0, jtag_on}, 0);

    // R3 other address
    bus_write(8'hC6, 8'h01); idle(1);
    read_reg(8'hC7, rd);
    check("R3", "neighbour write ignored", rd, 8'h00);
    bus_write(8'hC7, 8'h01);
    read_reg(8'hC6, rd);
    check("R3", "neighbour read zero", rd, 8'h00);
    bus_write(8'hC7, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule